// File: doc/BRIEF.md
# Serial Management Slave

This block is the slave end of a two-wire serial management bus. It is clocked by the bus clock and shares one bidirectional data line with the host. It watches the line for a read or write command, checks the device address, and reaches a 32-entry by 16-bit register file through a simple read/write port. The register file itself sits outside the block.

No preamble is needed. Bits that arrive before a command are ignored, provided they do not form a command pattern. The low three bits of the device address come from strap pins and are captured while reset is asserted. The two upper address bits must be zero, so eight devices can share one bus. A read releases the line for turnaround and then shifts out the register contents. A write captures 16 data bits and commits them with a one-cycle strobe. Every command takes two trailing clocks before the slave listens for the next one.

Top module: `mdio_slave_top`

## Requirements
- R1: A read command (pattern 0110, then a 5-bit device address and a 5-bit register address, both MSB first) to a matching device returns the addressed register in frame bits 17 to 32, most significant bit first.
- R2: A write command (pattern 0101, the two addresses, a 2-bit turnaround field and 16 data bits MSB first) to a matching device raises `reg_we_o` for exactly one cycle, in frame slot 33, with the register address and data of the frame.
- R3: A command is recognised without a preamble. It is also recognised after any run of idle ones or idle zeros that does not contain a command pattern.
- R4: The device address matches only when its top two bits are zero and its low three bits equal the value on `strap_i` while `rst_ni` was low. Changes on `strap_i` after reset have no effect.
- R5: When the address does not match, the slave never enables its output and never strobes a write. It still counts the full 34-slot frame.
- R6: During a matching read, the slave leaves frame slot 15 undriven, drives 0 in slot 16, drives data in slots 17 to 32, and releases the line in slot 33.
- R7: Every frame occupies 34 clock slots. A command pattern that begins in slot 33 or 34 is not recognised. A command that begins in slot 35 is served normally.
- R8: During and after reset, before any command, `mdio_oe_o` and `reg_we_o` are low.
- R9: Four-bit groups other than 0110 and 0101, such as 0111 or 0100, start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock; the data line is sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; the strap is captured while low |
| strap_i | input | 3 | Low bits of the device address |
| mdio_i | input | 1 | Data line as seen at the pin |
| mdio_o | output | 1 | Data the slave drives |
| mdio_oe_o | output | 1 | Output enable for the data line |
| reg_addr_o | output | 5 | Register file address |
| reg_wdata_o | output | 16 | Register file write data |
| reg_we_o | output | 1 | One-cycle register file write strobe |
| reg_rdata_i | input | 16 | Register file read data for `reg_addr_o` |

## Verification
Frames are sent after no idle bits, after runs of idle ones and after runs of idle zeros. This shows that pattern detection needs no preamble and is not thrown off by what comes before it. Device addresses are varied in the upper bits, in the strapped bits, and after the strap pins change, which separates a matching device from a silent one. Frames are placed back to back, with a pattern started one slot early and with a frame started at slot 35, to pin down the 34-slot frame length. Near-miss patterns (0111, 0100) show that only the two true command codes open a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] PAT_RD = 4'b0110;
  localparam logic [OP_W-1:0] PAT_WR = 4'b0101;
  typedef enum logic {ST_IDLE, ST_FRAME} fsm_t;
endpackage

// File: rtl/mdio_start_det.sv
module mdio_start_det
  import mdio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdio_i,
  input  logic idle_i,
  output logic start_o,
  output logic start_rd_o
);
  logic [OP_W-2:0] hist_q;
  logic [OP_W-1:0] win;

  assign win        = {hist_q, mdio_i};
  assign start_rd_o = (win == PAT_RD);
  assign start_o    = idle_i && ((win == PAT_RD) || (win == PAT_WR));

  // history is flushed to ones while a frame runs, so a new pattern needs fresh idle bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '1;
    else if (!idle_i) hist_q <= '1;
    else              hist_q <= win[OP_W-2:0];
  end

  AST_START_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(idle_i)); // R7
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3,
  localparam int HDR_END   = OP_W + PHY_W + REG_W,
  localparam int TA_END    = HDR_END + 2,
  localparam int DATA_END  = TA_END + DATA_W,
  localparam int FRAME_END = DATA_END + 2,
  localparam int CNT_W     = $clog2(FRAME_END + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mdio_i,
  input  logic               start_i,
  input  logic               start_rd_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               rd_hit_o,
  output logic [REG_W-1:0]   addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               we_o
);
  localparam int HDR_W = PHY_W + REG_W;
  localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W - 1 : DATA_W - 1;

  fsm_t              st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic              is_rd_q, match_q, we_q;
  logic [REG_W-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [HDR_W-1:0]  hdr_w;
  logic [PHY_W-1:0]  own_phy;

  assign hdr_w   = {sh_q[HDR_W-2:0], mdio_i};
  assign own_phy = {{(PHY_W-STRAP_W){1'b0}}, strap_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; is_rd_q <= 1'b0;
      match_q <= 1'b0; addr_q <= '0; wdata_q <= '0; we_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_FRAME;
          cnt_q   <= CNT_W'(OP_W);
          is_rd_q <= start_rd_i;
          match_q <= 1'b0;
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= {sh_q[SH_W-2:0], mdio_i};
          if (cnt_q == CNT_W'(HDR_END - 1)) begin
            match_q <= (hdr_w[HDR_W-1:REG_W] == own_phy);
            addr_q  <= hdr_w[REG_W-1:0];
          end
          if (cnt_q == CNT_W'(DATA_END - 1) && !is_rd_q && match_q) begin
            we_q    <= 1'b1;
            wdata_q <= {sh_q[DATA_W-2:0], mdio_i};
          end
          if (cnt_q == CNT_W'(FRAME_END - 1)) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o   = (st_q == ST_FRAME);
  assign cnt_o    = cnt_q;
  assign rd_hit_o = is_rd_q && match_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q); // R2
  AST_WE_AFTER_D0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (cnt_q == CNT_W'(DATA_END))); // R2
  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(cnt_q) == CNT_W'(FRAME_END - 1))); // R7
endmodule

// File: rtl/mdio_rd_shift.sv
module mdio_rd_shift #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int HDR_END = 14,
  localparam int TA_END   = HDR_END + 2,
  localparam int DATA_END = TA_END + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              rd_hit_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mdio_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] sh_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; oe_q <= 1'b0;
    end else if (!busy_i || !rd_hit_i) begin
      oe_q <= 1'b0;
    end else begin
      if (cnt_i == CNT_W'(HDR_END)) begin
        oe_q <= 1'b1;           // second turnaround slot driven low
        sh_q <= '0;
      end
      if (cnt_i == CNT_W'(TA_END - 1)) sh_q <= rdata_i;
      if (cnt_i >= CNT_W'(TA_END) && cnt_i <= CNT_W'(DATA_END - 2))
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      if (cnt_i == CNT_W'(DATA_END - 1)) oe_q <= 1'b0;
    end
  end

  assign oe_o   = oe_q;
  assign mdio_o = oe_q & sh_q[DATA_W-1];

  AST_TA_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !mdio_o); // R6
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> (cnt_i == CNT_W'(DATA_END))); // R6
  AST_OE_HIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> rd_hit_i); // R5
endmodule

// File: rtl/mdio_slave_top.sv
module mdio_slave_top #(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [REG_W-1:0]   reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);
  localparam int HDR_END   = mdio_pkg::OP_W + PHY_W + REG_W;
  localparam int FRAME_END = HDR_END + 2 + DATA_W + 2;
  localparam int CNT_W     = $clog2(FRAME_END + 1);

  logic [STRAP_W-1:0] strap_q;
  logic               start, start_rd, busy, rd_hit;
  logic [CNT_W-1:0]   cnt;

  // strap pins are transparent only while reset is held
  always_latch begin
    if (!rst_ni) strap_q = strap_i;
  end

  mdio_start_det u_det (
    .clk_i, .rst_ni, .mdio_i,
    .idle_i(!busy), .start_o(start), .start_rd_o(start_rd)
  );

  mdio_frame_ctrl #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_ctrl (
    .clk_i, .rst_ni, .mdio_i,
    .start_i(start), .start_rd_i(start_rd), .strap_i(strap_q),
    .busy_o(busy), .cnt_o(cnt), .rd_hit_o(rd_hit),
    .addr_o(reg_addr_o), .wdata_o(reg_wdata_o), .we_o(reg_we_o)
  );

  mdio_rd_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HDR_END(HDR_END)) u_rd (
    .clk_i, .rst_ni, .busy_i(busy), .cnt_i(cnt), .rd_hit_i(rd_hit),
    .rdata_i(reg_rdata_i), .mdio_o, .oe_o(mdio_oe_o)
  );

  AST_WE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !mdio_oe_o); // R2
  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(strap_q)); // R4
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !mdio_oe_o); // R7
endmodule

// File: tb/tb_mdio_slave_top.sv
module tb_mdio_slave_top;
  localparam logic [2:0] STRAP = 3'd3;
  localparam int NS = 128;
  // {idle value, idle count, write, dev addr, reg addr, data}
  localparam logic [30:0] VEC [10] = '{
    {1'b1, 3'd2, 1'b1, 5'd3,  5'd3,  16'hA5A5},
    {1'b0, 3'd5, 1'b1, 5'd3,  5'd31, 16'h1234},
    {1'b1, 3'd0, 1'b0, 5'd3,  5'd3,  16'h0000},
    {1'b0, 3'd3, 1'b1, 5'd11, 5'd3,  16'hFFFF},
    {1'b1, 3'd1, 1'b1, 5'd7,  5'd3,  16'h0000},
    {1'b0, 3'd7, 1'b0, 5'd3,  5'd3,  16'h0000},
    {1'b1, 3'd0, 1'b0, 5'd3,  5'd31, 16'h0000},
    {1'b1, 3'd4, 1'b1, 5'd3,  5'd0,  16'h8001},
    {1'b1, 3'd0, 1'b0, 5'd3,  5'd0,  16'h0000},
    {1'b0, 3'd2, 1'b0, 5'd19, 5'd0,  16'h0000}
  };

  logic clk = 1'b0, rst_n, host_en, host_bit, mdio_line;
  logic [2:0] strap;
  logic mdio_o, mdio_oe_o, reg_we_o;
  logic [4:0] reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i;
  logic [15:0] mem [32];
  logic [15:0] exp_mem [32];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic drv_a [1:NS];
  logic en_a  [1:NS];
  logic oe_s  [1:NS];
  logic out_s [1:NS];
  logic we_s  [1:NS];
  logic [4:0]  wa_s [1:NS];
  logic [15:0] wd_s [1:NS];

  always #4 clk = ~clk;

  assign mdio_line   = host_en ? host_bit : (mdio_oe_o ? mdio_o : 1'b1);
  assign reg_rdata_i = mem[reg_addr_o];

  always_ff @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 32; i++) mem[i] <= 16'(i * 16'h0111) ^ 16'h3C00;
    else if (reg_we_o) mem[reg_addr_o] <= reg_wdata_o;
  end

  mdio_slave_top dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .mdio_i(mdio_line),
    .mdio_o, .mdio_oe_o, .reg_addr_o, .reg_wdata_o, .reg_we_o, .reg_rdata_i
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int k = 1; k <= NS; k++) begin drv_a[k] = 1'b1; en_a[k] = 1'b0; end
  endtask

  task automatic put_bits(input int st, input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin drv_a[st+i] = v[n-1-i]; en_a[st+i] = 1'b1; end
  endtask

  task automatic put_frame(input int st, input bit wr, input logic [4:0] t, input logic [4:0] a,
                           input logic [15:0] d);
    if (wr) put_bits(st, {4'b0101, t, a, 2'b10, d}, 32);
    else    put_bits(st, {18'd0, 4'b0110, t, a}, 14);
  endtask

  // each slot: sample outputs set by the previous edge, then drive the next bit
  task automatic run(input int n);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      oe_s[k] = mdio_oe_o; out_s[k] = mdio_o; we_s[k] = reg_we_o;
      wa_s[k] = reg_addr_o; wd_s[k] = reg_wdata_o;
      host_en = en_a[k]; host_bit = drv_a[k];
    end
  endtask

  function automatic int cnt_we(input int lo, input int hi);
    int c = 0;
    for (int k = lo; k <= hi; k++) if (we_s[k]) c++;
    return c;
  endfunction

  function automatic int cnt_oe(input int lo, input int hi);
    int c = 0;
    for (int k = lo; k <= hi; k++) if (oe_s[k]) c++;
    return c;
  endfunction

  function automatic logic [15:0] rd_word(input int st);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = out_s[st+16+i];
    return r;
  endfunction

  task automatic read_check(input logic [4:0] a, input logic [15:0] exp, input string req);
    clr(); put_frame(1, 1'b0, 5'd3, a, 16'h0); run(34);
    chk(rd_word(1) == exp, req, rd_word(1), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_en = 1'b0; host_bit = 1'b1; strap = STRAP;
    for (int i = 0; i < 32; i++) exp_mem[i] = 16'(i * 16'h0111) ^ 16'h3C00;
    repeat (3) @(negedge clk);
    chk(!mdio_oe_o && !reg_we_o, "R8 reset outputs", {mdio_oe_o, reg_we_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mdio_oe_o && !reg_we_o, "R8 idle after reset", {mdio_oe_o, reg_we_o}, 0);

    for (int v = 0; v < 10; v++) begin
      logic [30:0] e;
      int idle, st;
      logic wr, hit;
      logic [4:0] t, a;
      logic [15:0] d;
      e = VEC[v];
      idle = int'(e[29:27]); wr = e[26]; t = e[25:21]; a = e[20:16]; d = e[15:0];
      hit = (t == {2'b00, STRAP});
      st = idle + 1;
      clr();
      for (int i = 1; i <= idle; i++) begin drv_a[i] = e[30]; en_a[i] = 1'b1; end
      put_frame(st, wr, t, a, d);
      run(idle + 34);
      if (wr && hit) begin
        chk(cnt_we(1, idle + 34) == 1 && we_s[st+32] && wa_s[st+32] == a && wd_s[st+32] == d,
            "R2/R3 write commit", {11'd0, wa_s[st+32], wd_s[st+32]}, {11'd0, a, d});
        exp_mem[a] = d;
      end else if (wr) begin
        chk(cnt_we(1, idle + 34) == 0, "R4/R5 foreign write ignored", cnt_we(1, idle + 34), 0);
        chk(cnt_oe(1, idle + 34) == 0, "R5 no drive on write", cnt_oe(1, idle + 34), 0);
      end else if (hit) begin
        chk(rd_word(st) == exp_mem[a], "R1/R3 read data", rd_word(st), exp_mem[a]);
        chk(!oe_s[st+14] && oe_s[st+15] && !out_s[st+15], "R6 turnaround",
            {oe_s[st+14], oe_s[st+15], out_s[st+15]}, 3'b010);
        chk(oe_s[st+31] && !oe_s[st+32] && cnt_oe(1, idle + 34) == 17, "R6 release after D0",
            cnt_oe(1, idle + 34), 17);
      end else begin
        chk(cnt_oe(1, idle + 34) == 0, "R4/R5 foreign read silent", cnt_oe(1, idle + 34), 0);
      end
    end

    // R9: near-miss patterns open no frame
    clr(); put_bits(1, 32'b0111, 4); put_bits(20, 32'b0100, 4); run(60);
    chk(cnt_oe(1, 60) == 0 && cnt_we(1, 60) == 0, "R9 near-miss patterns",
        cnt_oe(1, 60) + cnt_we(1, 60), 0);
    read_check(5'd31, exp_mem[31], "R9 read after near-miss");

    // R7: a pattern started in slot 34 is ignored
    clr(); put_frame(1, 1'b1, 5'd3, 5'd5, 16'h5A5A);
    put_bits(34, {18'd0, 4'b0110, 5'd3, 5'd31}, 14);
    run(80);
    exp_mem[5] = 16'h5A5A;
    chk(cnt_we(1, 80) == 1 && we_s[33], "R2 strobe before overlap", cnt_we(1, 80), 1);
    chk(cnt_oe(34, 80) == 0, "R7 early pattern ignored", cnt_oe(34, 80), 0);

    // R7: a command starting in slot 35 is served
    clr(); put_frame(1, 1'b1, 5'd3, 5'd6, 16'h0F0F); put_frame(35, 1'b0, 5'd3, 5'd6, 16'h0);
    run(70);
    exp_mem[6] = 16'h0F0F;
    chk(rd_word(35) == 16'h0F0F, "R7 back-to-back read", rd_word(35), 16'h0F0F);

    // R4: strap changes after reset have no effect
    strap = 3'd6;
    read_check(5'd5, exp_mem[5], "R4 latched strap still matches");
    clr(); put_frame(1, 1'b0, 5'd6, 5'd5, 16'h0); run(34);
    chk(cnt_oe(1, 34) == 0, "R4 new strap value ignored", cnt_oe(1, 34), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule